// File: doc/BRIEF.md
# Quadword Promotion Move Unit

This unit executes a single register-to-register move. A 64-bit value is taken from an 8-entry legacy SIMD register file and placed in the low half of one entry of a 16-entry 128-bit vector register file, with the upper half cleared. At the same time the floating-point stack bookkeeping is switched over to SIMD use: the stack-top field returns to zero and every tag entry is marked valid.

Before anything is committed, the unit checks the full decoded encoding (prefix, escape, opcode and ModRM bytes) and a set of control and feature bits. It then reports at most one fault, chosen by fixed priority. A faulting instruction changes no architectural state.

Control is a two-state machine. In `S_IDLE`, `req_ready` is high. A request with `req_valid` high takes the transition `T_ACCEPT` into `S_REPORT`. In that transition the commit or the fault is registered, and the retire or fault pulse shows in `S_REPORT`. `S_REPORT` always takes `T_RELEASE` back to `S_IDLE` on the next clock. Reset enters `S_IDLE`. The source file is filled through its own write port. The destination file is observed through a combinational read port.

Top module: `qw_promote_unit`

## Requirements
- R1: Synchronous active-high reset leaves every source and destination entry at zero, `stack_top` at 0 and `tag_word` at 16'hFFFF (every 2-bit tag at 11b, empty). After reset `req_ready` is high and no pulse is raised.
- R2: A request is accepted when `req_valid` and `req_ready` are both high. In the following cycle exactly one of `retire_pulse` and `fault_pulse` is high for one cycle, and `req_ready` is low.
- R3: The move is recognised only when `req_pfx`=8'hF3, `req_esc`=8'h0F, `req_opc`=8'hD6 and ModRM bits 7:6 equal 11b. Any other encoding raises fault code 1 (undefined opcode).
- R4: The destination index is {`req_rex_r`, ModRM bits 5:3}, covering entries 0 to 15. The source index is ModRM bits 2:0.
- R5: On retire, destination bits 63:0 take the source value and destination bits 127:64 become zero.
- R6: On retire, `stack_top` becomes 0 and `tag_word` becomes 16'h0000 (all tags valid).
- R7: Fault code 1 is raised when `ctl_emulate` is 1, `ctl_os_save` is 0, `feat_vec2` is 0, or `req_lock` is 1.
- R8: Fault code 2 (device not available) is raised when `ctl_task_sw` is 1.
- R9: Fault code 3 (math fault) is raised when `fp_pending` is 1.
- R10: When several faults apply, code 1 wins over code 2 and code 2 wins over code 3. `fault_code` is 0 whenever `fault_pulse` is low.
- R11: A faulting request leaves both register files, `stack_top` and `tag_word` unchanged.
- R12: When `src_we` is high, `src_wdata` is written to source entry `src_waddr` at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_pfx | input | 8 | Mandatory prefix byte |
| req_lock | input | 1 | Lock prefix present |
| req_esc | input | 8 | Escape byte |
| req_opc | input | 8 | Opcode byte |
| req_modrm | input | 8 | ModRM byte |
| req_rex_r | input | 1 | Destination index extension bit |
| ctl_task_sw | input | 1 | Task-switched control bit (control word bit 3) |
| ctl_emulate | input | 1 | Emulation control bit (control word bit 2) |
| ctl_os_save | input | 1 | OS save/restore enable (extended control bit 9) |
| feat_vec2 | input | 1 | Vector-extension feature bit (feature word bit 26) |
| fp_pending | input | 1 | Pending floating-point exception |
| src_we | input | 1 | Source file write enable |
| src_waddr | input | 3 | Source file write index |
| src_wdata | input | 64 | Source file write data |
| dst_raddr | input | 4 | Destination file read index |
| dst_rdata | output | 128 | Destination file read data |
| retire_pulse | output | 1 | Move committed |
| fault_pulse | output | 1 | Move faulted |
| fault_code | output | 2 | 0 none, 1 undefined opcode, 2 device not available, 3 math |
| stack_top | output | 3 | Floating-point stack-top field |
| tag_word | output | 16 | Eight 2-bit tags |

## Verification
On every cycle the assertions check the handshake and pulse timing (R2), that retire and fault never coincide, that the fault code agrees with the pulse kind (R10), that `stack_top` and `tag_word` take their post-commit values on retire (R6), and that these fields hold still across faults and idle cycles (R11). Other behaviours can only be shown by the bench's sweeps. These are the mapping of destination and source indices to data (R4, R5), the resolution of every combination of fault conditions by priority (R7 to R10), the rejection of near-miss encodings (R3), and the fact that a fault leaves the destination file untouched.

// File: rtl/qpu_pkg.sv
package qpu_pkg;
    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_UD   = 2'd1,
        FLT_NM   = 2'd2,
        FLT_MF   = 2'd3
    } fault_e;

    typedef enum logic {
        S_IDLE   = 1'b0,
        S_REPORT = 1'b1
    } state_e;

    localparam logic [7:0] PFX_REP  = 8'hF3;
    localparam logic [7:0] ESC_BYTE = 8'h0F;
    localparam logic [7:0] OPC_MOVE = 8'hD6;
endpackage

// File: rtl/qpu_decode.sv
module qpu_decode
    import qpu_pkg::*;
#(
    parameter int SRC_AW = 3,
    parameter int DST_AW = 4
) (
    input  logic [7:0]        pfx,
    input  logic              lock_pfx,
    input  logic [7:0]        esc,
    input  logic [7:0]        opc,
    input  logic [7:0]        modrm,
    input  logic              rex_r,
    input  logic              task_sw,
    input  logic              emulate,
    input  logic              os_save,
    input  logic              feat_ok,
    input  logic              fp_pend,
    output fault_e            verdict,
    output logic [DST_AW-1:0] dst_idx,
    output logic [SRC_AW-1:0] src_idx
);
    logic enc_match;
    logic ud_hit;

    assign enc_match = (pfx == PFX_REP) && (esc == ESC_BYTE) &&
                       (opc == OPC_MOVE) && (modrm[7:6] == 2'b11);
    assign ud_hit    = !enc_match || emulate || !os_save || !feat_ok || lock_pfx;
    assign dst_idx   = DST_AW'({rex_r, modrm[5:3]});
    assign src_idx   = SRC_AW'(modrm[2:0]);

    // fixed priority: undefined opcode, then device, then math
    always_comb begin
        if (ud_hit)       verdict = FLT_UD;
        else if (task_sw) verdict = FLT_NM;
        else if (fp_pend) verdict = FLT_MF;
        else              verdict = FLT_NONE;
    end
endmodule

// File: rtl/qpu_regfile.sv
module qpu_regfile #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr_a,
    output logic [WIDTH-1:0] rdata_a,
    input  logic [AW-1:0]    raddr_b,
    output logic [WIDTH-1:0] rdata_b
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst)                          mem_q[g] <= '0;
            else if (we && waddr == AW'(g))   mem_q[g] <= wdata;
        end
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/qw_promote_unit.sv
module qw_promote_unit
    import qpu_pkg::*;
#(
    parameter int SRC_DEPTH = 8,
    parameter int DST_DEPTH = 16,
    parameter int SRC_W     = 64,
    parameter int DST_W     = 128,
    parameter int STK_SLOTS = 8,
    localparam int SRC_AW   = $clog2(SRC_DEPTH),
    localparam int DST_AW   = $clog2(DST_DEPTH),
    localparam int TOS_W    = $clog2(STK_SLOTS),
    localparam int TAG_W    = 2 * STK_SLOTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_pfx,
    input  logic              req_lock,
    input  logic [7:0]        req_esc,
    input  logic [7:0]        req_opc,
    input  logic [7:0]        req_modrm,
    input  logic              req_rex_r,
    input  logic              ctl_task_sw,
    input  logic              ctl_emulate,
    input  logic              ctl_os_save,
    input  logic              feat_vec2,
    input  logic              fp_pending,
    input  logic              src_we,
    input  logic [SRC_AW-1:0] src_waddr,
    input  logic [SRC_W-1:0]  src_wdata,
    input  logic [DST_AW-1:0] dst_raddr,
    output logic [DST_W-1:0]  dst_rdata,
    output logic              retire_pulse,
    output logic              fault_pulse,
    output logic [1:0]        fault_code,
    output logic [TOS_W-1:0]  stack_top,
    output logic [TAG_W-1:0]  tag_word
);
    state_e              state_q, state_d;
    fault_e              verdict;
    logic [DST_AW-1:0]   dst_idx;
    logic [SRC_AW-1:0]   src_idx;
    logic [SRC_W-1:0]    src_val;
    logic [SRC_W-1:0]    src_unused;
    logic [DST_W-1:0]    dst_unused;
    logic                accept;
    logic                commit;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;
    assign commit    = accept && (verdict == FLT_NONE);

    qpu_decode #(.SRC_AW(SRC_AW), .DST_AW(DST_AW)) decode_i (
        .pfx(req_pfx), .lock_pfx(req_lock), .esc(req_esc), .opc(req_opc),
        .modrm(req_modrm), .rex_r(req_rex_r), .task_sw(ctl_task_sw),
        .emulate(ctl_emulate), .os_save(ctl_os_save), .feat_ok(feat_vec2),
        .fp_pend(fp_pending), .verdict(verdict), .dst_idx(dst_idx),
        .src_idx(src_idx)
    );

    qpu_regfile #(.DEPTH(SRC_DEPTH), .WIDTH(SRC_W)) src_file_i (
        .clk(clk), .rst(rst), .we(src_we), .waddr(src_waddr),
        .wdata(src_wdata), .raddr_a(src_idx), .rdata_a(src_val),
        .raddr_b('0), .rdata_b(src_unused)
    );

    qpu_regfile #(.DEPTH(DST_DEPTH), .WIDTH(DST_W)) dst_file_i (
        .clk(clk), .rst(rst), .we(commit), .waddr(dst_idx),
        .wdata({{(DST_W-SRC_W){1'b0}}, src_val}),
        .raddr_a(dst_raddr), .rdata_a(dst_rdata),
        .raddr_b('0), .rdata_b(dst_unused)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (accept) state_d = S_REPORT;   // T_ACCEPT
            S_REPORT: state_d = S_IDLE;                 // T_RELEASE
            default:  state_d = S_IDLE;
        endcase
    end

    // registered outputs and stack bookkeeping
    always_ff @(posedge clk) begin
        if (rst) begin
            retire_pulse <= 1'b0;
            fault_pulse  <= 1'b0;
            fault_code   <= FLT_NONE;
            stack_top    <= '0;
            tag_word     <= '1;
        end else begin
            retire_pulse <= 1'b0;
            fault_pulse  <= 1'b0;
            fault_code   <= FLT_NONE;
            unique case (state_q)
                S_IDLE: if (accept) begin
                    if (verdict == FLT_NONE) begin
                        retire_pulse <= 1'b1;
                        stack_top    <= '0;
                        tag_word     <= '0;
                    end else begin
                        fault_pulse  <= 1'b1;
                        fault_code   <= verdict;
                    end
                end
                S_REPORT: ;
                default: ;
            endcase
        end
    end

    logic unused_ok;
    assign unused_ok = ^{src_unused, dst_unused};
endmodule

// File: rtl/qw_promote_unit_chk.sv
module qw_promote_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        retire_pulse,
    input logic        fault_pulse,
    input logic [1:0]  fault_code,
    input logic [2:0]  stack_top,
    input logic [15:0] tag_word
);
    // R2: an accepted request yields one pulse next cycle, with ready low
    a_r2_pulse_follows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> ((retire_pulse || fault_pulse) && !req_ready));

    // R2: a pulse only after an accepted request
    a_r2_no_stray_pulse: assert property (@(posedge clk) disable iff (rst)
        (retire_pulse || fault_pulse) |-> $past(req_valid && req_ready));

    // R2: never both pulses
    a_r2_one_outcome: assert property (@(posedge clk) disable iff (rst)
        $onehot0({retire_pulse, fault_pulse}));

    // R10: code nonzero exactly with a fault pulse
    a_r10_code_match: assert property (@(posedge clk) disable iff (rst)
        (fault_pulse == (fault_code != 2'd0)));

    // R6: retire leaves stack top at 0 and all tags valid
    a_r6_stack_reset: assert property (@(posedge clk) disable iff (rst)
        retire_pulse |-> (stack_top == 3'd0 && tag_word == 16'h0000));

    // R11: tag word and stack top change only with a retire
    a_r11_hold_state: assert property (@(posedge clk) disable iff (rst)
        !retire_pulse |-> ($stable(tag_word) && $stable(stack_top)));
endmodule

bind qw_promote_unit qw_promote_unit_chk chk_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .retire_pulse(retire_pulse), .fault_pulse(fault_pulse),
    .fault_code(fault_code), .stack_top(stack_top), .tag_word(tag_word)
);

// File: tb/qw_promote_unit_tb_top.sv
module qw_promote_unit_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [7:0]   req_pfx = 8'h00, req_esc = 8'h00, req_opc = 8'h00, req_modrm = 8'h00;
    logic         req_lock = 1'b0, req_rex_r = 1'b0;
    logic         ctl_task_sw = 1'b0, ctl_emulate = 1'b0, ctl_os_save = 1'b1;
    logic         feat_vec2 = 1'b1, fp_pending = 1'b0;
    logic         src_we = 1'b0;
    logic [2:0]   src_waddr = '0;
    logic [63:0]  src_wdata = '0;
    logic [3:0]   dst_raddr = '0;
    logic [127:0] dst_rdata;
    logic         retire_pulse, fault_pulse;
    logic [1:0]   fault_code;
    logic [2:0]   stack_top;
    logic [15:0]  tag_word;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    qw_promote_unit dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_pfx(req_pfx), .req_lock(req_lock), .req_esc(req_esc),
        .req_opc(req_opc), .req_modrm(req_modrm), .req_rex_r(req_rex_r),
        .ctl_task_sw(ctl_task_sw), .ctl_emulate(ctl_emulate),
        .ctl_os_save(ctl_os_save), .feat_vec2(feat_vec2),
        .fp_pending(fp_pending), .src_we(src_we), .src_waddr(src_waddr),
        .src_wdata(src_wdata), .dst_raddr(dst_raddr), .dst_rdata(dst_rdata),
        .retire_pulse(retire_pulse), .fault_pulse(fault_pulse),
        .fault_code(fault_code), .stack_top(stack_top), .tag_word(tag_word)
    );

    function automatic logic [63:0] src_pat(int i, int salt);
        return {32'hC0DE_0000 + 32'(i) + 32'(salt << 8),
                32'h1000_0001 * 32'(i + 1 + salt)};
    endfunction

    task automatic check(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_src(int salt);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            src_we = 1'b1; src_waddr = 3'(i); src_wdata = src_pat(i, salt);
        end
        @(negedge clk);
        src_we = 1'b0;
    endtask

    // issue one request, return observed pulses/code in the report cycle
    task automatic issue(input logic [7:0] pfx, esc, opc, modrm, input logic rexr,
                         output logic ret, output logic flt, output logic [1:0] code,
                         output logic rdy);
        @(negedge clk);
        req_valid = 1'b1; req_pfx = pfx; req_esc = esc; req_opc = opc;
        req_modrm = modrm; req_rex_r = rexr;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ret = retire_pulse; flt = fault_pulse; code = fault_code; rdy = req_ready;
        @(posedge clk);
    endtask

    function automatic logic [127:0] rd_dst_expect(int d);
        return 128'h0;
    endfunction

    logic       r_ret, r_flt, r_rdy;
    logic [1:0] r_code;

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(stack_top == 3'd0, "R1 stack_top", 128'(stack_top), 0);
        check(tag_word == 16'hFFFF, "R1 tag_word", 128'(tag_word), 128'hFFFF);
        check(req_ready && !retire_pulse && !fault_pulse, "R1 handshake idle",
              128'({req_ready, retire_pulse, fault_pulse}), 128'b100);
        for (int d = 0; d < 16; d++) begin
            dst_raddr = 4'(d); #1;
            check(dst_rdata == rd_dst_expect(d), "R1 dst entry zero", dst_rdata, 0);
        end

        // R12: fill source file; its effect is shown through retired moves below
        load_src(0);

        // R7 R8 R9 R10 R11: sweep all 32 control combinations with lock off/on
        for (int m = 0; m < 64; m++) begin
            logic [1:0] exp_code;
            logic em, osn, ftn, lk, ts, pd;
            em = m[0]; osn = m[1]; ftn = m[2]; lk = m[3]; ts = m[4]; pd = m[5];
            exp_code = (em || osn || ftn || lk) ? 2'd1 : ts ? 2'd2 : pd ? 2'd3 : 2'd0;
            if (exp_code == 2'd0) continue;
            @(negedge clk);
            ctl_emulate = em; ctl_os_save = !osn; feat_vec2 = !ftn;
            req_lock = lk; ctl_task_sw = ts; fp_pending = pd;
            issue(8'hF3, 8'h0F, 8'hD6, {2'b11, 3'(m % 8), 3'(m % 8)}, m[1],
                  r_ret, r_flt, r_code, r_rdy);
            check(r_flt && !r_ret && r_code == exp_code, "R10 fault priority",
                  128'({r_flt, r_ret, r_code}), 128'({1'b1, 1'b0, exp_code}));
            if (exp_code == 2'd1 && lk) check(r_code == 2'd1, "R7 lock gives code 1", 128'(r_code), 1);
            if (exp_code == 2'd2) check(r_code == 2'd2, "R8 task switch", 128'(r_code), 2);
            if (exp_code == 2'd3) check(r_code == 2'd3, "R9 pending math", 128'(r_code), 3);
            check(!r_rdy, "R2 ready low in report", 128'(r_rdy), 0);
        end
        ctl_emulate = 0; ctl_os_save = 1; feat_vec2 = 1; req_lock = 0;
        ctl_task_sw = 0; fp_pending = 0;
        @(negedge clk);
        // R11: faults touched nothing
        check(tag_word == 16'hFFFF && stack_top == 0, "R11 stack after faults",
              128'(tag_word), 128'hFFFF);
        for (int d = 0; d < 16; d++) begin
            dst_raddr = 4'(d); #1;
            check(dst_rdata == 128'h0, "R11 dst untouched", dst_rdata, 0);
        end

        // R3: near-miss encodings
        for (int k = 0; k < 6; k++) begin
            logic [7:0] p, e, o, mr;
            p = 8'hF3; e = 8'h0F; o = 8'hD6; mr = 8'hC1;
            case (k)
                0: p = 8'hF2;
                1: p = 8'h66;
                2: e = 8'h0E;
                3: o = 8'hD7;
                4: mr = 8'h81;
                default: mr = 8'h01;
            endcase
            issue(p, e, o, mr, 1'b0, r_ret, r_flt, r_code, r_rdy);
            check(r_flt && !r_ret && r_code == 2'd1, "R3 bad encoding",
                  128'({r_flt, r_code}), 128'b101);
        end

        // R4 R5 R6: all destination/source pairs
        for (int d = 0; d < 16; d++) begin
            for (int s = 0; s < 8; s++) begin
                issue(8'hF3, 8'h0F, 8'hD6, {2'b11, 3'(d % 8), 3'(s)}, d >= 8,
                      r_ret, r_flt, r_code, r_rdy);
                check(r_ret && !r_flt && r_code == 0, "R2 retire pulse",
                      128'({r_ret, r_flt, r_code}), 128'b1000);
                @(negedge clk);
                dst_raddr = 4'(d); #1;
                check(dst_rdata == {64'h0, src_pat(s, 0)}, "R5 R4 move data",
                      dst_rdata, {64'h0, src_pat(s, 0)});
            end
        end
        check(stack_top == 0 && tag_word == 16'h0000, "R6 stack after retire",
              128'(tag_word), 0);
        for (int d = 0; d < 16; d++) begin
            dst_raddr = 4'(d); #1;
            check(dst_rdata == {64'h0, src_pat(7, 0)}, "R4 final entries",
                  dst_rdata, {64'h0, src_pat(7, 0)});
        end

        // R12: rewrite sources, then fault leaves dest but retire picks new value
        load_src(5);
        @(negedge clk); fp_pending = 1'b1;
        issue(8'hF3, 8'h0F, 8'hD6, 8'hC0 | 8'h03, 1'b1, r_ret, r_flt, r_code, r_rdy);
        @(negedge clk); fp_pending = 1'b0; dst_raddr = 4'd8; #1;
        check(dst_rdata == {64'h0, src_pat(7, 0)}, "R11 dst kept on math fault",
              dst_rdata, {64'h0, src_pat(7, 0)});
        issue(8'hF3, 8'h0F, 8'hD6, 8'hC0 | 8'h03, 1'b1, r_ret, r_flt, r_code, r_rdy);
        @(negedge clk); dst_raddr = 4'd8; #1;
        check(dst_rdata == {64'h0, src_pat(3, 5)}, "R12 new source value",
              dst_rdata, {64'h0, src_pat(3, 5)});

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule